// File: doc/BRIEF.md
# TLB Entry Permission and Translation Checker

This block takes a TLB entry pair that an earlier lookup has already matched and turns it into a translation result. It picks one half of the pair using the address bit at the page-size position. It then runs the access-rights checks in a fixed order and reports the first fault it finds. If there is no fault, it forms the physical address and a read/write/execute protection mask. The result is registered, so it appears one clock after the request.

Two operating modes are supported. In the wide (64-bit) mode, each entry half carries no-execute, no-read and restricted-privilege bits. In the narrow (32-bit) mode, those three bits are ignored. The page size comes from one of two places: a single global size for entries of the set-associative array, or the entry's own size field for entries of the fully-associative array. The caller selects which.

Top module: `tlbchk_top`

## Requirements
- R1: While rst_ni is low, and after it rises until the first request, res_vld_o, res_code_o, paddr_o and prot_o are all 0.
- R2: A request sampled with req_vld_i=1 at a rising edge gives res_vld_o=1 with its result after that edge. A rising edge with req_vld_i=0 gives res_vld_o=0, res_code_o=0, paddr_o=0 and prot_o=0.
- R3: The page size PS (valid range 12 to 30) is ent_ps_i when use_own_ps_i=1 and glob_ps_i when use_own_ps_i=0.
- R4: The odd half ent_odd_i is used when vaddr_i[PS]=1, and the even half ent_even_i otherwise. Each half is laid out as follows: bit 0 valid, bit 1 dirty, bits 3:2 privilege level, bit 4 no-execute, bit 5 no-read, bit 6 restricted-privilege, bit 7 unused, bits EW-1:8 page number.
- R5: Access types are encoded fetch=0, load=1, store=2. The value 3 triggers none of the type-specific faults.
- R6: res_code_o follows this priority, highest first: invalid=1 (valid bit clear); execute-inhibit=2 (fetch with no-execute set); read-inhibit=3 (load with no-read set); privilege=4; dirty=5 (store with dirty clear). Only when none apply is the code match=0.
- R7: A privilege fault occurs when restricted-privilege=0 and cur_plv_i is numerically greater than the entry level. When restricted-privilege=1, it occurs whenever cur_plv_i differs from the entry level.
- R8: When mode64_i=0, the no-execute, no-read and restricted-privilege bits are treated as 0.
- R9: On a match, the page-number bits that fall below PS-12 are cleared. paddr_o is then the masked page number shifted left by 12, ORed with vaddr_i[PS-1:0].
- R10: On a match, prot_o[0] (read) is 1, prot_o[1] (write) equals the dirty bit, and prot_o[2] (execute) is the inverse of the effective no-execute bit.
- R11: When res_code_o is not match, paddr_o and prot_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Request valid |
| mode64_i | input | 1 | 1 = wide mode, 0 = narrow mode |
| acc_type_i | input | 2 | Access type (fetch=0, load=1, store=2) |
| cur_plv_i | input | 2 | Current privilege level |
| vaddr_i | input | VA_W | Virtual address |
| use_own_ps_i | input | 1 | Take the page size from the entry |
| ent_ps_i | input | PSW | Entry page size |
| glob_ps_i | input | PSW | Global page size |
| ent_even_i | input | EW | Even half of the pair |
| ent_odd_i | input | EW | Odd half of the pair |
| res_vld_o | output | 1 | Result valid |
| res_code_o | output | 3 | Result code |
| paddr_o | output | PA_W | Physical address |
| prot_o | output | 3 | Protection mask {exec, write, read} |

## Verification
The directed patterns are built so that each one is decided by exactly one rule:
- Half selection is tried with a valid half on one side and an invalid half on the other, so choosing the wrong half changes the result code.
- The page-size source is tried with a global size and an entry size that select opposite halves.
- Fault-ordering cases stack two or more faults, so an out-of-order ladder reports the wrong code.
- Privilege cases compare a lower level against a higher entry level with strict mode off and then on.
- A narrow-mode fetch with no-execute and restricted-privilege set separates ignored bits from honoured ones.
- A page number with its low bits set at a 64 KiB page shows whether masking is applied.

Random pairs, levels and page sizes are then compared against a behavioural model on every cycle.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int ATTR_W     = 8;
  localparam int B_V        = 0;
  localparam int B_D        = 1;
  localparam int B_PLV      = 2;
  localparam int B_NX       = 4;
  localparam int B_NR       = 5;
  localparam int B_RPLV     = 6;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_INVALID = 3'd1,
    RES_XI      = 3'd2,
    RES_RI      = 3'd3,
    RES_PE      = 3'd4,
    RES_DIRTY   = 3'd5
  } res_code_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  typedef struct packed {
    logic       v;
    logic       d;
    logic [1:0] plv;
    logic       nx;
    logic       nr;
    logic       rplv;
  } attr_t;
endpackage

// File: rtl/tlbchk_half_sel.sv
module tlbchk_half_sel
  import tlbchk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PSW  = 5,
  parameter int EW   = 44,
  localparam int PPN_W = EW - ATTR_W
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             mode64_i,
  input  logic             use_own_ps_i,
  input  logic [PSW-1:0]   ent_ps_i,
  input  logic [PSW-1:0]   glob_ps_i,
  input  logic [EW-1:0]    ent_even_i,
  input  logic [EW-1:0]    ent_odd_i,
  output logic [PSW-1:0]   ps_o,
  output attr_t            attr_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic [EW-1:0] half;
  logic          odd;

  always_comb begin
    ps_o = use_own_ps_i ? ent_ps_i : glob_ps_i;
    odd  = vaddr_i[ps_o];
    half = odd ? ent_odd_i : ent_even_i;
    attr_o.v    = half[B_V];
    attr_o.d    = half[B_D];
    attr_o.plv  = half[B_PLV +: 2];
    // narrow mode carries no inhibit / strict-level bits
    attr_o.nx   = mode64_i & half[B_NX];
    attr_o.nr   = mode64_i & half[B_NR];
    attr_o.rplv = mode64_i & half[B_RPLV];
    ppn_o = half[EW-1:ATTR_W];
  end
endmodule

// File: rtl/tlbchk_fault.sv
module tlbchk_fault
  import tlbchk_pkg::*;
(
  input  attr_t      attr_i,
  input  logic [1:0] acc_type_i,
  input  logic [1:0] cur_plv_i,
  output res_code_e  code_o
);
  logic plv_bad;

  always_comb begin
    plv_bad = attr_i.rplv ? (cur_plv_i != attr_i.plv) : (cur_plv_i > attr_i.plv);
    if (!attr_i.v)                                     code_o = RES_INVALID;
    else if (acc_type_i == ACC_FETCH && attr_i.nx)     code_o = RES_XI;
    else if (acc_type_i == ACC_LOAD  && attr_i.nr)     code_o = RES_RI;
    else if (plv_bad)                                  code_o = RES_PE;
    else if (acc_type_i == ACC_STORE && !attr_i.d)     code_o = RES_DIRTY;
    else                                               code_o = RES_MATCH;
  end
endmodule

// File: rtl/tlbchk_xlate.sv
module tlbchk_xlate
  import tlbchk_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PA_W  = 48,
  parameter int PSW   = 5,
  parameter int PPN_W = 36
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PSW-1:0]   ps_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  attr_t            attr_i,
  input  res_code_e        code_i,
  output logic [PA_W-1:0]  paddr_o,
  output logic [2:0]       prot_o
);
  localparam int BASE_W = PPN_W + PAGE_SHIFT;

  logic [PPN_W-1:0]  low_clr;
  logic [PPN_W-1:0]  ppn_m;
  logic [BASE_W-1:0] base;
  logic [PA_W-1:0]   off_mask;
  logic [PA_W-1:0]   va_ext;

  always_comb begin
    low_clr  = (PPN_W'(1) << (ps_i - PSW'(PAGE_SHIFT))) - PPN_W'(1);
    ppn_m    = ppn_i & ~low_clr;
    base     = {ppn_m, {PAGE_SHIFT{1'b0}}};
    off_mask = (PA_W'(1) << ps_i) - PA_W'(1);
    va_ext   = PA_W'(vaddr_i);
    if (code_i == RES_MATCH) begin
      paddr_o = PA_W'(base) | (va_ext & off_mask);
      prot_o  = {~attr_i.nx, attr_i.d, 1'b1};
    end else begin
      paddr_o = '0;
      prot_o  = '0;
    end
  end
endmodule

// File: rtl/tlbchk_top.sv
module tlbchk_top
  import tlbchk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48,
  parameter int PSW  = 5,
  localparam int PPN_W = PA_W - PAGE_SHIFT,
  localparam int EW    = PPN_W + ATTR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_vld_i,
  input  logic             mode64_i,
  input  logic [1:0]       acc_type_i,
  input  logic [1:0]       cur_plv_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             use_own_ps_i,
  input  logic [PSW-1:0]   ent_ps_i,
  input  logic [PSW-1:0]   glob_ps_i,
  input  logic [EW-1:0]    ent_even_i,
  input  logic [EW-1:0]    ent_odd_i,
  output logic             res_vld_o,
  output logic [2:0]       res_code_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [2:0]       prot_o
);
  logic [PSW-1:0]   ps;
  attr_t            attr;
  logic [PPN_W-1:0] ppn;
  res_code_e        code;
  logic [PA_W-1:0]  paddr_c;
  logic [2:0]       prot_c;

  tlbchk_half_sel #(.VA_W(VA_W), .PSW(PSW), .EW(EW)) u_sel (
    .vaddr_i, .mode64_i, .use_own_ps_i, .ent_ps_i, .glob_ps_i,
    .ent_even_i, .ent_odd_i,
    .ps_o(ps), .attr_o(attr), .ppn_o(ppn)
  );

  tlbchk_fault u_fault (
    .attr_i(attr), .acc_type_i, .cur_plv_i, .code_o(code)
  );

  tlbchk_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PSW(PSW), .PPN_W(PPN_W)) u_xlate (
    .vaddr_i, .ps_i(ps), .ppn_i(ppn), .attr_i(attr), .code_i(code),
    .paddr_o(paddr_c), .prot_o(prot_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o  <= 1'b0;
      res_code_o <= '0;
      paddr_o    <= '0;
      prot_o     <= '0;
    end else if (req_vld_i) begin
      res_vld_o  <= 1'b1;
      res_code_o <= code;
      paddr_o    <= paddr_c;
      prot_o     <= prot_c;
    end else begin
      res_vld_o  <= 1'b0;
      res_code_o <= '0;
      paddr_o    <= '0;
      prot_o     <= '0;
    end
  end
endmodule

// File: rtl/tlbchk_sva.sv
module tlbchk_sva #(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_vld_i,
  input logic            mode64_i,
  input logic            res_vld_o,
  input logic [2:0]      res_code_o,
  input logic [PA_W-1:0] paddr_o,
  input logic [2:0]      prot_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  assert_vld_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> res_vld_o == $past(req_vld_i));

  assert_idle_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> (res_code_o == 3'd0 && prot_o == 3'd0 && paddr_o == '0));

  assert_code_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> res_code_o <= 3'd5);

  assert_read_on_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && res_code_o == 3'd0) |-> prot_o[0]);

  assert_fault_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && res_code_o != 3'd0) |-> (prot_o == 3'd0 && paddr_o == '0));

  assert_narrow_no_inhibit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && res_vld_o && !$past(mode64_i)) |-> (res_code_o != 3'd2 && res_code_o != 3'd3 && prot_o[2] == (res_code_o == 3'd0)));
endmodule

bind tlbchk_top tlbchk_sva #(.VA_W(VA_W), .PA_W(PA_W)) u_sva (
  .clk_i, .rst_ni, .req_vld_i, .mode64_i,
  .res_vld_o, .res_code_o, .paddr_o, .prot_o
);

// File: tb/tlbchk_top_bench.sv
module tlbchk_top_bench;
  localparam int VA_W = 48;
  localparam int PA_W = 48;
  localparam int PSW  = 5;
  localparam int EW   = PA_W - 12 + 8;

  logic clk = 0;
  logic rst_ni = 0;
  logic req_vld = 0, mode64 = 1, use_own = 0;
  logic [1:0] acc = 0, plv = 0;
  logic [VA_W-1:0] va = 0;
  logic [PSW-1:0] eps = 5'd14, gps = 5'd14;
  logic [EW-1:0] e_even = 0, e_odd = 0;
  logic res_vld;
  logic [2:0] res_code, prot;
  logic [PA_W-1:0] paddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  tlbchk_top u_tlbchk_top (
    .clk_i(clk), .rst_ni, .req_vld_i(req_vld), .mode64_i(mode64),
    .acc_type_i(acc), .cur_plv_i(plv), .vaddr_i(va), .use_own_ps_i(use_own),
    .ent_ps_i(eps), .glob_ps_i(gps), .ent_even_i(e_even), .ent_odd_i(e_odd),
    .res_vld_o(res_vld), .res_code_o(res_code), .paddr_o(paddr), .prot_o(prot)
  );

  function automatic logic [EW-1:0] mk(bit v, bit d, int lv, bit nx, bit nr, bit rp,
                                       longint unsigned pg);
    logic [EW-1:0] e;
    e = '0;
    e[0] = v; e[1] = d; e[3:2] = 2'(lv); e[4] = nx; e[5] = nr; e[6] = rp;
    e[EW-1:8] = (EW-8)'(pg);
    return e;
  endfunction

  // behavioural reference: returns {code, prot, paddr}
  function automatic logic [53:0] model();
    int s, lv;
    logic [EW-1:0] e;
    bit v, d, nx, nr, rp;
    int code;
    longint unsigned pg, pa;
    logic [2:0] pr;
    s  = use_own ? int'(eps) : int'(gps);
    e  = va[s] ? e_odd : e_even;
    v  = e[0]; d = e[1]; lv = int'(e[3:2]);
    nx = mode64 ? e[4] : 0;
    nr = mode64 ? e[5] : 0;
    rp = mode64 ? e[6] : 0;
    if (!v) code = 1;
    else if (acc == 0 && nx) code = 2;
    else if (acc == 1 && nr) code = 3;
    else if ((rp == 0 && int'(plv) > lv) || (rp == 1 && int'(plv) != lv)) code = 4;
    else if (acc == 2 && !d) code = 5;
    else code = 0;
    pa = 0; pr = 0;
    if (code == 0) begin
      pg = longint'(e[EW-1:8]);
      pa = ((pg >> (s - 12)) << s) | (longint'(va) % (64'd1 << s));
      pr = {~nx, d, 1'b1};
    end
    return {3'(code), pr, 48'(pa)};
  endfunction

  task automatic chk(string tag, longint got, longint exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // called at a negedge with inputs set; checks after the next posedge
  task automatic step(string tag, int exp_code);
    logic [53:0] m;
    m = model();
    @(negedge clk);
    chk(tag, res_vld, 1, "vld");
    chk(tag, res_code, exp_code < 0 ? longint'(m[53:51]) : exp_code, "code");
    chk(tag, prot, m[50:48], "prot");
    chk(tag, paddr, m[47:0], "paddr");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {res_vld, res_code, prot}, 0, "in reset");
    chk("R1", paddr, 0, "paddr in reset");
    rst_ni = 1;
    @(negedge clk);
    chk("R1", {res_vld, res_code, prot}, 0, "after reset");

    req_vld = 1; gps = 14; use_own = 0; mode64 = 1;
    // R4: even half valid, odd invalid
    e_even = mk(1, 1, 3, 0, 0, 0, 36'h00ABC); e_odd = mk(0, 1, 3, 0, 0, 0, 0);
    acc = 1; plv = 0; va = 48'h0000_0000_2123;
    step("R4_even", 0);
    va = 48'h0000_0000_6123;
    step("R4_odd", 1);
    // R3: own size 16 picks odd via bit16, global would pick even
    use_own = 1; eps = 16;
    e_even = mk(0, 0, 0, 0, 0, 0, 0); e_odd = mk(1, 1, 3, 0, 0, 0, 36'h00770);
    va = 48'h0000_0001_0456;
    step("R3_own", 0);
    use_own = 0;
    step("R3_glob", 1);
    // R6 ladder
    e_even = mk(0, 0, 0, 1, 1, 0, 0); acc = 0; plv = 3; va = 48'h1000;
    step("R6_invalid_first", 1);
    e_even = mk(1, 0, 0, 1, 1, 0, 0);
    step("R6_xi", 2);
    acc = 1;
    step("R6_ri", 3);
    acc = 2;
    step("R6_pe_over_dirty", 4);
    plv = 0;
    step("R6_dirty", 5);
    acc = 3;
    step("R5_type3", 0);
    // R7
    acc = 1; e_even = mk(1, 1, 3, 0, 0, 1, 5); plv = 0;
    step("R7_strict_lower", 4);
    plv = 3;
    step("R7_strict_equal", 0);
    e_even = mk(1, 1, 1, 0, 0, 0, 5); plv = 0;
    step("R7_loose_lower", 0);
    plv = 2;
    step("R7_loose_higher", 4);
    // R8 narrow mode ignores nx, rplv, nr
    mode64 = 0; acc = 0; plv = 0; e_even = mk(1, 0, 3, 1, 1, 1, 9);
    step("R8_fetch", 0);
    chk("R8", prot, 3'b101, "prot exec");
    acc = 1;
    step("R8_load", 0);
    mode64 = 1;
    // R9 masking, 64 KiB page
    use_own = 1; eps = 16; e_even = mk(1, 1, 0, 0, 0, 0, 36'h1234F);
    va = 48'h0005_0000_ABCD; va[16] = 0;
    step("R9_mask", 0);
    chk("R9", paddr, 48'h1234ABCD, "paddr literal");
    // R10
    e_even = mk(1, 0, 0, 1, 0, 0, 36'h1230);
    step("R10_ro_nx", 0);
    chk("R10", prot, 3'b001, "prot literal");
    // R11
    e_even = mk(1, 1, 0, 0, 1, 0, 36'hFFFF);
    step("R11_fault", 3);
    chk("R11", {prot, paddr}, 0, "zeros");
    // R2 idle
    req_vld = 0;
    @(negedge clk);
    chk("R2", {res_vld, res_code, prot}, 0, "idle outputs");
    chk("R2", paddr, 0, "idle paddr");
    req_vld = 1;
    // random against model
    for (int i = 0; i < 400; i++) begin
      mode64  = 1'($urandom);
      use_own = 1'($urandom);
      eps = 5'(12 + $urandom_range(0, 18));
      gps = 5'(12 + $urandom_range(0, 18));
      acc = 2'($urandom);
      plv = 2'($urandom);
      va  = {16'($urandom), 32'($urandom)};
      e_even = {12'($urandom), 32'($urandom)};
      e_odd  = {12'($urandom), 32'($urandom)};
      e_even[0] = ($urandom_range(0, 3) != 0);
      e_odd[0]  = ($urandom_range(0, 3) != 0);
      step("R6_R9_rand", -1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule